// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Walker

This block moves the data of one disk command between a local sector buffer and host memory. The host memory region can be split into pieces. A start strobe gives the engine the address of a descriptor table and the transfer direction. The engine reads one 8-byte descriptor at a time over a dedicated fetch port. It then streams the region that descriptor names through a 16-bit memory port, two bytes per beat. Moving on to the next descriptor stays hidden from the buffer side, because the buffer word index keeps counting across all regions of the command.

A descriptor is read from the fetch port as one 64-bit word. It holds a region base address, a byte count and a flags halfword whose top bit ends the table. The memory port can refuse a beat. After a refusal the engine backs off for a fixed number of cycles and then offers the same beat again. An abort input drops the engine back to idle at any point.

Top module: `prd_dma_walker`

## Requirements
- R1: Out of reset the outputs `busy`, `done`, `dsc_req` and `mem_req` are low. While idle, a `start` pulse latches `tbl_base` and `to_mem`. The first descriptor request, at address `tbl_base`, appears in the following cycle.
- R2: The descriptor layout on `dsc_rdata` is: bits [31:0] region address, bits [47:32] byte count, bits [63:48] flags. Bit 0 of both the address and the count is forced to zero.
- R3: A region of N effective bytes is moved in N/2 beats. The beats go to consecutive addresses that rise by 2 from the effective region address.
- R4: A count halfword of zero describes a region of 65536 bytes, which is 32768 beats.
- R5: Each descriptor is fetched 8 bytes after the previous one. A region whose effective count is zero (a count of 1) moves no data, and the walk continues.
- R6: With `to_mem`=1, every beat writes memory (`mem_we`=1) with `buf_rdata` at `buf_idx`. With `to_mem`=0, every beat reads memory and writes `mem_rdata` to the buffer through `buf_we`. `buf_idx` starts at 0 and rises by one per beat across the whole command.
- R7: A beat offered while `mem_busy` is high does not happen. `mem_req` then stays low for exactly BACKOFF cycles, and the same address is offered again.
- R8: Only bit 15 of the flags marks the final descriptor; the other flag bits have no effect. `done` is a single-cycle pulse in the cycle after the final beat of the marked region, or after the fetch of a marked empty region. `busy` is low in that same cycle.
- R9: An `abort` returns the engine to idle in the next cycle. After that no request is issued and `done` is never raised for the aborted command.
- R10: A `start` pulse while busy is ignored. The walk in progress continues with its original table and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted when idle) |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| tbl_base | input | 32 | Descriptor table address |
| abort | input | 1 | Stop the command and return to idle |
| dsc_req | output | 1 | Descriptor fetch request |
| dsc_addr | output | 32 | Descriptor fetch address |
| dsc_ack | input | 1 | Descriptor data valid this cycle |
| dsc_rdata | input | 64 | Descriptor word |
| mem_req | output | 1 | Data beat request |
| mem_we | output | 1 | Beat writes memory |
| mem_addr | output | 32 | Beat byte address (even) |
| mem_wdata | output | 16 | Write data |
| mem_busy | input | 1 | Memory refuses the current beat |
| mem_rdata | input | 16 | Read data, valid in the beat cycle |
| buf_idx | output | BUF_AW | Sector buffer word index |
| buf_rdata | input | 16 | Buffer word at `buf_idx` |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |

## Verification
Several rules are checked on every cycle: the quiet window after a refused beat and the retry at its end, the +2 address step between accepted beats, the +8 step between descriptor fetches, even beat addresses, the idle silence after an abort, and the one-cycle `done` pulse. Some behaviour can only be shown by the bench's scenarios, because it depends on what the table holds. This covers the decoded region addresses and lengths, the 64 KiB case, skipping empty regions, the data moved in each direction, the buffer index, and the point where `done` fires. The bench sweeps direction against table lengths, with and without refusals. It also covers a start issued while busy and an abort partway through a region.

// File: rtl/prd_dma_walker.sv
module prd_dma_walker #(
  parameter int BUF_AW  = 12,
  parameter int BACKOFF = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic [31:0]       tbl_base,
  input  logic              abort,
  output logic              dsc_req,
  output logic [31:0]       dsc_addr,
  input  logic              dsc_ack,
  input  logic [63:0]       dsc_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_busy,
  input  logic [15:0]       mem_rdata,
  output logic [BUF_AW-1:0] buf_idx,
  input  logic [15:0]       buf_rdata,
  output logic              buf_we,
  output logic [15:0]       buf_wdata,
  output logic              busy,
  output logic              done
);

  localparam int BOW = $clog2(BACKOFF + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;

  state_t            st;
  logic              dir_w, last, done_q;
  logic [31:0]       dptr, raddr;
  logic [16:0]       rem;
  logic [BOW-1:0]    boff;
  logic [BUF_AW-1:0] bidx;

  wire [15:0] cnt_h   = dsc_rdata[47:32];
  wire [16:0] eff_cnt = (cnt_h == 16'd0) ? 17'h10000 : {1'b0, cnt_h & 16'hFFFE};
  wire        eot     = dsc_rdata[63];
  wire        unused_bits = &{1'b0, dsc_rdata[62:48], dsc_rdata[0]};

  assign dsc_req   = (st == S_FETCH);
  assign dsc_addr  = dptr;
  assign mem_req   = (st == S_XFER) && (boff == '0);
  assign mem_we    = dir_w;
  assign mem_addr  = raddr;
  assign mem_wdata = buf_rdata;
  wire   beat      = mem_req & ~mem_busy;
  assign buf_idx   = bidx;
  assign buf_we    = beat & ~dir_w;
  assign buf_wdata = mem_rdata;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_w  <= 1'b0;
      last   <= 1'b0;
      done_q <= 1'b0;
      dptr   <= '0;
      raddr  <= '0;
      rem    <= '0;
      boff   <= '0;
      bidx   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        st   <= S_IDLE;
        boff <= '0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st    <= S_FETCH;
            dptr  <= tbl_base;
            dir_w <= to_mem;
            bidx  <= '0;
          end
          S_FETCH: if (dsc_ack) begin
            raddr <= {dsc_rdata[31:1], 1'b0};
            rem   <= eff_cnt;
            last  <= eot;
            dptr  <= dptr + 32'd8;
            if (eff_cnt != 17'd0) st <= S_XFER;
            else if (eot) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
          S_XFER: begin
            if (mem_req && mem_busy) boff <= BOW'(BACKOFF);
            else if (boff != '0)     boff <= boff - BOW'(1);
            if (beat) begin
              raddr <= raddr + 32'd2;
              rem   <= rem - 17'd2;
              bidx  <= bidx + BUF_AW'(1);
              if (rem == 17'd2) begin
                if (last) begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                end else st <= S_FETCH;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/prd_dma_walker_chk.sv
module prd_dma_walker_chk #(
  parameter int BACKOFF = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        abort,
  input logic        busy,
  input logic        done,
  input logic        dsc_req,
  input logic        dsc_ack,
  input logic [31:0] dsc_addr,
  input logic        mem_req,
  input logic        mem_busy,
  input logic [31:0] mem_addr
);

  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= '0;
    else if (abort)            gap <= '0;
    else if (mem_req && mem_busy) gap <= 32'(BACKOFF);
    else if (gap != '0)        gap <= gap - 32'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dsc_req)); // R1
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req && !mem_busy) && !$past(abort)) |-> mem_addr == $past(mem_addr) + 32'd2); // R3
  AST_DSC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && $past(dsc_req && dsc_ack) && !$past(abort)) |-> dsc_addr == $past(dsc_addr) + 32'd8); // R5
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != '0) |-> !mem_req); // R7
  AST_GAP_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == 32'd1 && !abort) |=> mem_req); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_req && !dsc_req && !done && !busy)); // R9

endmodule

bind prd_dma_walker prd_dma_walker_chk #(.BACKOFF(BACKOFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .busy(busy), .done(done),
  .dsc_req(dsc_req), .dsc_ack(dsc_ack), .dsc_addr(dsc_addr),
  .mem_req(mem_req), .mem_busy(mem_busy), .mem_addr(mem_addr)
);

// File: tb/prd_dma_walker_tb.sv
module prd_dma_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BAW = 8;
  localparam int BO  = 6;
  localparam logic [31:0] TBL = 32'h0000_1000;

  logic clk = 0, rst_n = 0, start = 0, to_mem = 0, abort = 0;
  logic [31:0] tbl_base = 0;
  logic dsc_req, dsc_ack = 0, mem_req, mem_we, mem_busy = 0, buf_we, busy, done;
  logic [31:0] dsc_addr, mem_addr;
  logic [63:0] dsc_rdata = 0;
  logic [15:0] mem_wdata, mem_rdata, buf_rdata, buf_wdata;
  logic [BAW-1:0] buf_idx;

  logic [15:0] mem_arr [0:255];
  logic [15:0] buf_arr [0:255];
  logic [31:0] d_base [0:7];
  logic [15:0] d_cnt  [0:7];
  logic [15:0] d_flg  [0:7];

  assign mem_rdata = mem_arr[mem_addr[8:1]];
  assign buf_rdata = buf_arr[buf_idx];

  prd_dma_walker #(.BUF_AW(BAW), .BACKOFF(BO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .tbl_base(tbl_base),
    .abort(abort), .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack),
    .dsc_rdata(dsc_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_busy(mem_busy), .mem_rdata(mem_rdata),
    .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit dir, busy_mode, active, finished, done_due, gap_pend, refused;
  int di, off, k, fidx, lat, done_cnt, ref_cyc;
  logic [31:0] ref_addr;

  function automatic logic [31:0] eb(int i); return d_base[i] & 32'hFFFF_FFFE; endfunction
  function automatic int ec(int i); return (d_cnt[i] == 0) ? 65536 : int'(d_cnt[i] & 16'hFFFE); endfunction
  function automatic bit el(int i); return d_flg[i][15]; endfunction
  function automatic logic [15:0] bpat(int i); return 16'hA500 ^ 16'((i & 255) * 259); endfunction
  function automatic logic [15:0] mpat(int w); return 16'h1111 + 16'(w * 1799); endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected < 190000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done || done_due) begin
        chk(done == done_due, "R8 done timing", done, done_due);
        if (done) done_cnt++;
      end
      done_due = 0;
      if (dsc_ack) dsc_ack = 0;
      else if (dsc_req && active) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          chk(dsc_addr == TBL + 32'(8 * fidx), "R5 descriptor address", dsc_addr, TBL + 8 * fidx);
          dsc_rdata = {d_flg[fidx], d_cnt[fidx], d_base[fidx]};
          dsc_ack = 1;
          if (ec(fidx) == 0 && el(fidx)) begin done_due = 1; finished = 1; end
          fidx++;
        end
      end
      mem_busy = 0;
      if (active && mem_req) begin
        if (gap_pend) begin
          gap_pend = 0;
          chk(cyc - ref_cyc == BO + 1, "R7 backoff length", cyc - ref_cyc, BO + 1);
          chk(mem_addr == ref_addr, "R7 retry address", mem_addr, ref_addr);
        end
        if (busy_mode && (k % 5 == 2) && !refused) begin
          mem_busy = 1; refused = 1; gap_pend = 1; ref_cyc = cyc; ref_addr = mem_addr;
        end else begin
          refused = 0;
          if (off == 0) chk(mem_addr[0] == 0 && mem_addr == eb(di), "R2 region address", mem_addr, eb(di));
          else chk(mem_addr == eb(di) + 32'(off), "R3 beat address", mem_addr, eb(di) + off);
          chk(mem_we == dir && buf_idx == BAW'(k), "R6 direction/index", {mem_we, buf_idx}, {dir, BAW'(k)});
          if (dir) begin
            chk(mem_wdata == bpat(k) && !buf_we, "R6 write data", mem_wdata, bpat(k));
            mem_arr[mem_addr[8:1]] = mem_wdata;
          end else begin
            chk(buf_we && buf_wdata == mpat(int'(mem_addr[8:1])), "R6 read data", buf_wdata, mpat(int'(mem_addr[8:1])));
            buf_arr[buf_idx] = buf_wdata;
          end
          off += 2; k++;
          if (off == ec(di)) begin
            if (el(di)) begin done_due = 1; finished = 1; end
            else begin
              di++; off = 0;
              while (ec(di) == 0 && !el(di)) di++;
            end
          end
        end
      end
    end
  end

  task automatic run(input bit d, input int n, input bit bm, input bit glitch, input string tag);
    int tot = 0;
    for (int i = 0; i < n; i++) tot += ec(i) / 2;
    for (int i = 0; i < 256; i++) begin buf_arr[i] = bpat(i); mem_arr[i] = mpat(i); end
    dir = d; busy_mode = bm; di = 0; off = 0; k = 0; fidx = 0; lat = 0;
    finished = 0; done_cnt = 0; refused = 0; gap_pend = 0;
    while (ec(di) == 0 && !el(di)) di++;
    active = 1;
    @(negedge clk); start = 1; to_mem = d; tbl_base = TBL;
    @(negedge clk); start = 0; to_mem = ~d; tbl_base = 32'hDEAD_0000;
    chk(busy == 1 && dsc_req == 1 && dsc_addr == TBL, "R1 start latches table", dsc_addr, TBL);
    if (glitch) begin
      repeat (2) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    while (!finished) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R8 single done"}, done_cnt, 1);
    chk(k == tot, {tag, " R3 beat total"}, k, tot);
    chk(busy == 0, {tag, " R8 idle after"}, busy, 0);
    active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dsc_req && !mem_req, "R1 reset state", {busy, done, dsc_req, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    for (int dd = 0; dd < 2; dd++)
      for (int n = 1; n <= 3; n++) begin
        for (int i = 0; i < n; i++) begin
          d_base[i] = 32'h40 + 32'(i * 64) + ((i == 1) ? 32'd1 : 32'd0);
          d_cnt[i]  = 16'(6 + 4 * i + ((i == 0) ? 1 : 0));
          d_flg[i]  = (i == n - 1) ? 16'h8000 : 16'h0123;
        end
        run(dd[0], n, n == 3, (n == 2 && dd == 1), "R10 sweep");
      end

    d_base[0] = 32'h10; d_cnt[0] = 16'd8; d_flg[0] = 16'h7FFF;
    d_base[1] = 32'h80; d_cnt[1] = 16'd1; d_flg[1] = 16'h0000;
    d_base[2] = 32'h90; d_cnt[2] = 16'd4; d_flg[2] = 16'h8000;
    run(0, 3, 1, 0, "R5 empty middle");

    d_base[0] = 32'h20; d_cnt[0] = 16'd6; d_flg[0] = 16'h0000;
    d_base[1] = 32'h60; d_cnt[1] = 16'd1; d_flg[1] = 16'h8000;
    run(1, 2, 0, 0, "R5 empty last");

    d_base[0] = 32'h0002_0000; d_cnt[0] = 16'd0; d_flg[0] = 16'h8000;
    run(1, 1, 0, 0, "R4 64KiB region");

    d_base[0] = 32'h100; d_cnt[0] = 16'd200; d_flg[0] = 16'h8000;
    for (int i = 0; i < 256; i++) begin buf_arr[i] = bpat(i); mem_arr[i] = mpat(i); end
    dir = 1; busy_mode = 0; di = 0; off = 0; k = 0; fidx = 0; lat = 0; finished = 0; done_cnt = 0;
    active = 1;
    @(negedge clk); start = 1; to_mem = 1; tbl_base = TBL;
    @(negedge clk); start = 0;
    while (k < 20) @(negedge clk);
    active = 0; abort = 1;
    @(negedge clk); abort = 0;
    chk(!busy && !mem_req && !dsc_req && !done, "R9 idle after abort", {busy, mem_req, dsc_req, done}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!mem_req && !done && !busy, "R9 stays quiet", {mem_req, done, busy}, 0);
    end

    d_base[0] = 32'h30; d_cnt[0] = 16'd10; d_flg[0] = 16'h8000;
    run(0, 1, 0, 0, "R9 recovery");

    finish_run();
  end
endmodule